// File: doc/BRIEF.md
# TMDS Colour Channel Encoder

This block turns one 8-bit colour sample per pixel clock into a 10-bit symbol for a DC-balanced serial video link. Each symbol is built in two steps. The first step chains the data bits with XOR or XNOR, whichever gives fewer level changes on the wire, and keeps the choice in bit 8. The second step may invert the low eight bits so that the count of ones and zeros on the line stays level over time. Bit 9 marks whether that inversion was made.

While the video enable is low, the block sends one of four fixed control tokens, picked by a 2-bit blanking code, and clears its balance count. The symbol leaves a register one clock after its inputs are sampled. Three copies of the block, one per colour channel, sit in front of a serializer.

Top module: `tmds_chan_enc`

## Requirements
- R1: The symbol is registered. Inputs sampled at clock edge k appear on `tmds_sym` after edge k and hold until edge k+1. A synchronous reset drives the symbol to all zeros and the balance count to zero.
- R2: Stage one counts the ones in the byte. It picks XNOR chaining when the count exceeds four, or when the count is exactly four and bit 0 is 0. Otherwise it picks XOR. Chained bit 0 equals data bit 0. Chained bit i combines chained bit i-1 with data bit i. Symbol bit 8 is 1 for XOR and 0 for XNOR.
- R3: Call this the neutral case: the balance count is zero, or the chained low byte holds exactly four ones. In the neutral case, symbol bit 9 is the inverse of bit 8, and the low byte is sent inverted exactly when bit 8 is 0.
- R4: Outside the neutral case, the low byte is inverted and bit 9 set in two situations: the count is positive and the chained byte has more than four ones, or the count is negative and it has fewer than four. In every other case, bit 9 is 0 and the low byte passes unchanged. Bit 8 always carries the stage-one choice.
- R5: After each data symbol, the balance count grows by the number of ones minus the number of zeros in the emitted 10-bit symbol. It is held as a signed 5-bit value.
- R6: The balance count is always even and stays within -8 to +8.
- R7: With video enable low, the symbol is a token chosen by the blanking code, written here with bit 9 first: 00 gives 1101010100, 01 gives 0010101011, 10 gives 0101010100, and 11 gives 1010101011. The balance count returns to zero.
- R8: Every data symbol decodes back to its input byte. The decoder undoes the inversion when bit 9 is 1. It then un-chains with XOR when bit 8 is 1, or with XNOR when bit 8 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_byte | input | 8 | Colour sample for this pixel |
| video_on | input | 1 | High for active pixels, low during blanking |
| blank_code | input | 2 | Selects the control token while blanking |
| tmds_sym | output | 10 | Registered 10-bit line symbol |

## Verification
Three stimulus sets each target one part of the encoder:
- A sweep of all 256 byte values covers both chaining choices. It also hits the tie at four ones, where bytes such as 0x0F and 0x1E split on bit 0.
- Long runs of 0x00 and 0xFF push the balance count away from zero, and alternating 0x0F and 0xF0 swing its sign. These runs separate the positive and negative inversion branches from the neutral case.
- Random bytes mixed with blanking bursts of every code check the four tokens and the return of the count to zero, and a mid-stream reset checks recovery.

A behavioural model in the bench predicts each symbol. A separate decoder and disparity tracker read only the emitted symbols.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;

  localparam int TOK_W = 10;

  // Fixed line tokens sent while video is off (bit 9 leftmost).
  function automatic logic [TOK_W-1:0] blank_token(input logic [1:0] code);
    logic [TOK_W-1:0] t;
    case (code)
      2'b00:   t = 10'b1101010100;
      2'b01:   t = 10'b0010101011;
      2'b10:   t = 10'b0101010100;
      default: t = 10'b1010101011;
    endcase
    return t;
  endfunction

  // Decoder used by the checker: undo inversion, then undo chaining.
  function automatic logic [7:0] unchain(input logic [9:0] s);
    logic [7:0] lo;
    logic [7:0] d;
    lo = s[9] ? ~s[7:0] : s[7:0];
    d[0] = lo[0];
    for (int i = 1; i < 8; i++) begin
      d[i] = s[8] ? (lo[i] ^ lo[i-1]) : ~(lo[i] ^ lo[i-1]);
    end
    return d;
  endfunction

  // Ones minus zeros of a 10-bit symbol, signed 5-bit.
  function automatic logic signed [4:0] sym_bias(input logic [9:0] s);
    logic signed [4:0] acc;
    acc = '0;
    for (int i = 0; i < 10; i++) begin
      acc = s[i] ? acc + 5'sd1 : acc - 5'sd1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/tmds_tm_stage.sv
module tmds_tm_stage #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  output logic [DW:0]   qm,
  output logic          use_xnor
);
  localparam int HALF = DW / 2;
  localparam int CNTW = $clog2(DW + 1);

  logic [CNTW-1:0] ones;
  logic [DW-1:0]   chain;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DW; i++) begin
      ones = ones + CNTW'(din[i]);
    end
  end

  assign use_xnor = (ones > CNTW'(HALF)) ||
                    ((ones == CNTW'(HALF)) && !din[0]);

  always_comb begin
    chain[0] = din[0];
    for (int i = 1; i < DW; i++) begin
      chain[i] = use_xnor ? ~(chain[i-1] ^ din[i]) : (chain[i-1] ^ din[i]);
    end
  end

  assign qm = {~use_xnor, chain};

endmodule

// File: rtl/tmds_dc_balance.sv
module tmds_dc_balance #(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic [DW:0]          qm,
  input  logic signed [CW-1:0] disp_in,
  output logic [DW+1:0]        sym,
  output logic signed [CW-1:0] disp_out,
  output logic                 invert_word,
  output logic                 neutral_path
);
  localparam int SW = DW + 2;

  logic signed [CW-1:0] word_bias;
  logic signed [CW-1:0] sym_bias;
  logic disp_pos, disp_neg, word_heavy, word_light;

  always_comb begin
    word_bias = '0;
    for (int i = 0; i < DW; i++) begin
      word_bias = qm[i] ? word_bias + CW'(1) : word_bias - CW'(1);
    end
  end

  assign disp_neg   = disp_in[CW-1];
  assign disp_pos   = !disp_in[CW-1] && (disp_in != '0);
  assign word_light = word_bias[CW-1];
  assign word_heavy = !word_bias[CW-1] && (word_bias != '0);

  assign neutral_path = (disp_in == '0) || (word_bias == '0);

  always_comb begin
    if (neutral_path) begin
      invert_word = ~qm[DW];
    end else begin
      invert_word = (disp_pos && word_heavy) || (disp_neg && word_light);
    end
  end

  assign sym = {invert_word, qm[DW], invert_word ? ~qm[DW-1:0] : qm[DW-1:0]};

  always_comb begin
    sym_bias = '0;
    for (int i = 0; i < SW; i++) begin
      sym_bias = sym[i] ? sym_bias + CW'(1) : sym_bias - CW'(1);
    end
  end

  assign disp_out = disp_in + sym_bias;

endmodule

// File: rtl/tmds_ctl_token.sv
module tmds_ctl_token (
  input  logic [1:0] code,
  output logic [9:0] tok
);
  import tmds_enc_pkg::*;
  assign tok = blank_token(code);
endmodule

// File: rtl/tmds_chan_enc.sv
module tmds_chan_enc #(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pix_byte,
  input  logic          video_on,
  input  logic [1:0]    blank_code,
  output logic [DW+1:0] tmds_sym
);
  localparam int SW = DW + 2;

  logic [DW:0]          stage_word;
  logic                 use_xnor;
  logic [SW-1:0]        data_sym;
  logic [SW-1:0]        ctl_sym;
  logic signed [CW-1:0] disp_q;
  logic signed [CW-1:0] disp_next;
  logic                 invert_word;
  logic                 neutral_path;
  logic [SW-1:0]        sym_q;

  tmds_tm_stage #(.DW(DW)) u_tm (
    .din      (pix_byte),
    .qm       (stage_word),
    .use_xnor (use_xnor)
  );

  tmds_dc_balance #(.DW(DW), .CW(CW)) u_bal (
    .qm           (stage_word),
    .disp_in      (disp_q),
    .sym          (data_sym),
    .disp_out     (disp_next),
    .invert_word  (invert_word),
    .neutral_path (neutral_path)
  );

  generate
    if (SW == 10) begin : g_tok
      tmds_ctl_token u_tok (
        .code (blank_code),
        .tok  (ctl_sym)
      );
    end else begin : g_tok_none
      assign ctl_sym = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q  <= '0;
      disp_q <= '0;
    end else if (video_on) begin
      sym_q  <= data_sym;
      disp_q <= disp_next;
    end else begin
      sym_q  <= ctl_sym;
      disp_q <= '0;
    end
  end

  assign tmds_sym = sym_q;

endmodule

// File: rtl/tmds_chan_enc_chk.sv
module tmds_chan_enc_chk #(
  parameter int CW = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic [7:0]           pix_byte,
  input logic                 video_on,
  input logic [1:0]           blank_code,
  input logic [9:0]           sym,
  input logic signed [CW-1:0] disp
);
  import tmds_enc_pkg::*;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sym == '0 && disp == '0));

  p_token_r7: assert property (@(posedge clk) disable iff (rst)
    !video_on |=> (sym == blank_token($past(blank_code)) && disp == '0));

  p_roundtrip_r8: assert property (@(posedge clk) disable iff (rst)
    video_on |=> (unchain(sym) == $past(pix_byte)));

  p_disp_step_r5: assert property (@(posedge clk) disable iff (rst)
    video_on |=> (disp == $past(disp) + sym_bias(sym)));

  p_zero_path_r3: assert property (@(posedge clk) disable iff (rst)
    (video_on && disp == '0) |=> (sym[9] != sym[8]));

  p_disp_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (!disp[0] && disp >= -5'sd8 && disp <= 5'sd8));

endmodule

bind tmds_chan_enc tmds_chan_enc_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pix_byte   (pix_byte),
  .video_on   (video_on),
  .blank_code (blank_code),
  .sym        (tmds_sym),
  .disp       (disp_q)
);

// File: tb/tmds_chan_enc_tb.sv
module tmds_chan_enc_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pix_byte = '0;
  logic       video_on = 1'b0;
  logic [1:0] blank_code = '0;
  logic [9:0] tmds_sym;

  int n_tests = 0;
  int n_fail  = 0;
  int model_disp = 0;
  int trk_disp = 0;
  logic [9:0] prev_exp = '0;
  bit done = 0;

  always #5 clk = ~clk;

  tmds_chan_enc u_dut (
    .clk        (clk),
    .rst        (rst),
    .pix_byte   (pix_byte),
    .video_on   (video_on),
    .blank_code (blank_code),
    .tmds_sym   (tmds_sym)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: integer arithmetic, one symbol per call.
  task automatic model(input logic [7:0] b, input logic on, input logic [1:0] c,
                       output logic [9:0] s, output bit want_xor, output string tag);
    int n, n1;
    bit xn, inv;
    logic [7:0] q;
    if (!on) begin
      case (c)
        2'd0: s = 10'b1101010100;
        2'd1: s = 10'b0010101011;
        2'd2: s = 10'b0101010100;
        default: s = 10'b1010101011;
      endcase
      model_disp = 0;
      want_xor = 0;
      tag = "R7";
      return;
    end
    n  = $countones(b);
    xn = (n > 4) || (n == 4 && b[0] == 1'b0);
    want_xor = !xn;
    q[0] = b[0];
    for (int i = 1; i < 8; i++) q[i] = q[i-1] ^ b[i] ^ xn;
    n1 = $countones(q);
    if (model_disp == 0 || n1 == 4) begin
      inv = xn;
      tag = "R3";
    end else begin
      inv = (model_disp > 0 && n1 > 4) || (model_disp < 0 && n1 < 4);
      tag = "R4";
    end
    s = {inv, !xn, inv ? ~q : q};
    model_disp += 2 * $countones(s) - 10;
  endtask

  function automatic logic [7:0] decode(input logic [9:0] s);
    logic [7:0] lo, d;
    lo = s[9] ? ~s[7:0] : s[7:0];
    d[0] = lo[0];
    for (int i = 1; i < 8; i++) d[i] = lo[i] ^ lo[i-1] ^ !s[8];
    return d;
  endfunction

  task automatic step(input logic [7:0] b, input logic on, input logic [1:0] c);
    logic [9:0] exp;
    bit want_xor;
    string tag;
    pix_byte = b; video_on = on; blank_code = c;
    #1;
    chk(tmds_sym === prev_exp, "R1 hold until edge", tmds_sym, prev_exp);
    model(b, on, c, exp, want_xor, tag);
    @(negedge clk);
    chk(tmds_sym === exp, tag, tmds_sym, exp);
    if (on) begin
      chk(tmds_sym[8] == want_xor, "R2 chain select", tmds_sym[8], want_xor);
      chk(decode(tmds_sym) == b, "R8 decode", decode(tmds_sym), b);
      trk_disp += 2 * $countones(tmds_sym) - 10;
    end else begin
      trk_disp = 0;
    end
    chk(trk_disp == model_disp, "R5 disparity track", trk_disp, model_disp);
    chk(trk_disp >= -8 && trk_disp <= 8 && (trk_disp % 2 == 0), "R6 bound",
        trk_disp, 8);
    prev_exp = exp;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(tmds_sym === 10'd0, "R1 reset", tmds_sym, 0);
    rst = 1'b0;
    model_disp = 0;
    trk_disp = 0;
    prev_exp = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R7: all four tokens
    for (int c = 0; c < 4; c++) step(8'h00, 1'b0, 2'(c));
    // R2 tie cases: four ones, bit0 set vs clear
    step(8'h0F, 1'b1, 2'd0);
    step(8'h1E, 1'b1, 2'd0);
    // sweep all bytes (R2, R3, R4, R8)
    for (int v = 0; v < 256; v++) step(8'(v), 1'b1, 2'd0);
    // drive count positive and negative (R4)
    for (int k = 0; k < 12; k++) step(8'h00, 1'b1, 2'd0);
    for (int k = 0; k < 12; k++) step(8'hFF, 1'b1, 2'd0);
    for (int k = 0; k < 16; k++) step(k[0] ? 8'hF0 : 8'h0F, 1'b1, 2'd0);
    // blanking clears disparity (R7, R5)
    step(8'hA5, 1'b0, 2'd3);
    step(8'h01, 1'b1, 2'd0);
    // random data with blanking bursts
    for (int k = 0; k < 600; k++) begin
      if (k % 50 < 3) step(8'($urandom_range(255, 0)), 1'b0, 2'($urandom_range(3, 0)));
      else step(8'($urandom_range(255, 0)), 1'b1, 2'd0);
    end
    // mid-stream reset (R1)
    for (int k = 0; k < 5; k++) step(8'h07, 1'b1, 2'd0);
    do_reset();
    for (int k = 0; k < 20; k++) step(8'(k * 37), 1'b1, 2'd1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule